// File: doc/BRIEF.md
# Base Address Window Decoder

This block turns a device's programmed address windows into a hit/miss decision for incoming transactions. It takes a two-bit space-enable field from the command register, a set of base registers, and one expansion-ROM base register. Each window has a fixed power-of-two size, an address space (I/O or memory), and a flag that says whether the window exists. The block computes, combinationally, whether each window is currently live and what its aligned base and last address are. Values that cannot form a usable window, and space enables that are off, take the window out of the decode.

A requester presents an address, a space type and a valid strobe. On the next rising clock edge the block reports whether the address falls inside a live window of the same space, and which window it is. When windows overlap, the window with the lowest index is chosen. The register values are plain inputs. Holding them and moving data are left to the surrounding logic.

Top module: `bar_window_decoder`

## Requirements
- R1: A window of I/O type is live only while `cmd_en[0]` is 1, and a window of memory type only while `cmd_en[1]` is 1. Liveness is shown on `win_en` (bit i for window i) with no clock delay.
- R2: A window's base is its register value with the low log2(size) bits forced to zero. It covers every address from that base through base + size − 1 inclusive, and no address outside that range.
- R3: A window whose aligned base is zero is not live and never hits.
- R4: An I/O window whose last address is 0x10000 or higher is not live. An I/O window ending exactly at 0xFFFF stays live.
- R5: A window whose last address is not greater than its base is not live. A window of size one is such a window.
- R6: Window index NUM_BARS is the ROM window. It is always of memory type and is live only while bit 0 of `rom_reg` is 1.
- R7: A window marked absent by the `WIN_PRESENT` parameter (its size is treated as zero) is never live and never hits.
- R8: An access with `req_is_io`=1 matches only I/O windows. An access with `req_is_io`=0 matches only memory windows.
- R9: When an address falls in several live windows of its space, `hit_idx` reports the lowest window index.
- R10: `hit` and `hit_idx` are registered. They reflect the request sampled at the previous rising edge, and `hit` is 0 for a cycle whose request had `req_valid`=0.
- R11: While reset is active and right after it is released, `hit` is 0 and `hit_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_en | input | 2 | Bit 0 enables I/O decode, bit 1 enables memory decode |
| bar_regs | input | NUM_BARS*ADDR_W | Base registers, window i in bits [i*ADDR_W +: ADDR_W] |
| rom_reg | input | ADDR_W | ROM base register, bit 0 is the ROM enable |
| req_valid | input | 1 | Request strobe |
| req_is_io | input | 1 | 1 for an I/O access, 0 for a memory access |
| req_addr | input | ADDR_W | Request address |
| win_en | output | NUM_BARS+1 | Per-window live flag, combinational |
| hit | output | 1 | Registered hit flag |
| hit_idx | output | $clog2(NUM_BARS+1) | Registered index of the winning window |

## Verification
The bench uses the default parameters: 32-bit addresses and six base windows plus the ROM. The default window set has two I/O windows (16 and 256 bytes), memory windows of 4 KiB and 1 MiB, a size-one memory window, one absent window, and a 64 KiB ROM. With these sizes, small register values are enough to place a window on its first and last byte. They also let the bench overlap the 1 MiB window with the 4 KiB one to check priority, and move an I/O window onto the 64K limit. The size-one and absent windows bring the never-live cases within reach without changing any parameter.

// File: rtl/bardec_pkg.sv
`timescale 1ns/1ps
package bardec_pkg;
  localparam int CMD_IO_BIT  = 0;
  localparam int CMD_MEM_BIT = 1;
  // first address beyond the reachable I/O space
  localparam logic [31:0] IO_SPACE_END = 32'h0001_0000;
endpackage

// File: rtl/bardec_window.sv
`timescale 1ns/1ps
module bardec_window #(
  parameter int ADDR_W  = 32,
  parameter int LOG2    = 4,
  parameter bit IS_IO   = 1'b0,
  parameter bit PRESENT = 1'b1,
  parameter bit IS_ROM  = 1'b0
) (
  input  logic [ADDR_W-1:0] raw_i,
  input  logic              io_en_i,
  input  logic              mem_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              is_io_i,
  output logic              en_o,
  output logic              match_o
);
  import bardec_pkg::*;

  localparam logic [ADDR_W-1:0] SPAN_M1 = ADDR_W'((64'd1 << LOG2) - 64'd1);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] last;
  logic              space_on;
  logic              shape_ok;

  always_comb begin
    base     = raw_i & ~SPAN_M1;
    last     = base + SPAN_M1;
    space_on = IS_IO ? io_en_i : mem_en_i;
    shape_ok = (last > base) && (base != '0);
    if (IS_IO) begin
      shape_ok = shape_ok && (last < ADDR_W'(IO_SPACE_END));
    end
    if (IS_ROM) begin
      shape_ok = shape_ok && raw_i[0];
    end
    en_o    = PRESENT && space_on && shape_ok;
    match_o = en_o && (is_io_i == IS_IO) && (addr_i >= base) && (addr_i <= last);
  end
endmodule

// File: rtl/bardec_pick.sv
`timescale 1ns/1ps
module bardec_pick #(
  parameter int N     = 7,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] below;

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
    below = (N'(1) << idx_o) - N'(1);
    if (any_o) begin
      assert_lowest_wins_R9: assert (req_i[idx_o] && ((req_i & below) == '0))
        else $error("pick: index %0d is not the lowest request", idx_o);
    end
  end
endmodule

// File: rtl/bar_window_decoder.sv
`timescale 1ns/1ps
module bar_window_decoder #(
  parameter int ADDR_W   = 32,
  parameter int NUM_BARS = 6,
  parameter logic [(NUM_BARS+1)*8-1:0] WIN_LOG2 =
    {8'd16, 8'd0, 8'd0, 8'd20, 8'd8, 8'd12, 8'd4},
  parameter logic [NUM_BARS-1:0] WIN_IO      = 6'b000101,
  parameter logic [NUM_BARS:0]   WIN_PRESENT = 7'b1011111,
  localparam int NUM_WIN = NUM_BARS + 1,
  localparam int IDX_W   = $clog2(NUM_WIN)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cmd_en,
  input  logic [NUM_BARS*ADDR_W-1:0] bar_regs,
  input  logic [ADDR_W-1:0]          rom_reg,
  input  logic                       req_valid,
  input  logic                       req_is_io,
  input  logic [ADDR_W-1:0]          req_addr,
  output logic [NUM_WIN-1:0]         win_en,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);
  import bardec_pkg::*;

  localparam logic [NUM_WIN-1:0] IO_ALL = {1'b0, WIN_IO};

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NUM_WIN-1:0] win_match;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [ADDR_W-1:0] raw;
    if (i < NUM_BARS) begin : g_bar
      assign raw = bar_regs[i*ADDR_W +: ADDR_W];
    end else begin : g_rom
      assign raw = rom_reg;
    end
    bardec_window #(
      .ADDR_W (ADDR_W),
      .LOG2   (int'(WIN_LOG2[i*8 +: 8])),
      .IS_IO  (IO_ALL[i]),
      .PRESENT(WIN_PRESENT[i]),
      .IS_ROM (i == NUM_BARS)
    ) u_win (
      .raw_i   (raw),
      .io_en_i (cmd_en[CMD_IO_BIT]),
      .mem_en_i(cmd_en[CMD_MEM_BIT]),
      .addr_i  (req_addr),
      .is_io_i (req_is_io),
      .en_o    (win_en[i]),
      .match_o (win_match[i])
    );
  end

  logic             any_match;
  logic [IDX_W-1:0] pick_idx;

  bardec_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
    .req_i(win_match),
    .any_o(any_match),
    .idx_o(pick_idx)
  );

  logic             hit_d;
  logic             idx_ce;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    hit_d  = req_valid && any_match;
    idx_ce = hit_d;
    idx_d  = pick_idx;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      hit     <= 1'b0;
      hit_idx <= '0;
    end else begin
      hit <= hit_d;
      if (idx_ce) begin
        hit_idx <= idx_d;
      end
    end
  end

  assert_hit_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    hit |-> $past(req_valid));
  assert_io_gate_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    (hit && $past(req_is_io)) |-> $past(cmd_en[CMD_IO_BIT]));
  assert_mem_gate_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    (hit && !$past(req_is_io)) |-> $past(cmd_en[CMD_MEM_BIT]));
  assert_space_match_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    hit |-> ($past(req_is_io) == IO_ALL[hit_idx]));
  assert_rom_enable_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (hit && (hit_idx == IDX_W'(NUM_BARS))) |-> $past(rom_reg[0]));
  assert_nonzero_addr_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    hit |-> ($past(req_addr) != '0));
  assert_io_top_R4: assert property (@(posedge clk) disable iff (!rst_sync)
    (hit && $past(req_is_io)) |-> ($past(req_addr) < ADDR_W'(IO_SPACE_END)));
  assert_absent_R7: assert property (@(posedge clk) disable iff (!rst_sync)
    hit |-> WIN_PRESENT[hit_idx]);
endmodule

// File: tb/test_bar_window_decoder.sv
`timescale 1ns/1ps
module test_bar_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_en = 2'b00;
  logic [31:0] bars [6];
  logic [191:0] bar_regs;
  logic [31:0] rom_reg = '0;
  logic        req_valid = 1'b0;
  logic        req_is_io = 1'b0;
  logic [31:0] req_addr = '0;
  logic [6:0]  win_en;
  logic        hit;
  logic [2:0]  hit_idx;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++) bar_regs[i*32 +: 32] = bars[i];
  end

  bar_window_decoder i_bar_window_decoder (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .bar_regs(bar_regs),
    .rom_reg(rom_reg), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_addr(req_addr), .win_en(win_en), .hit(hit), .hit_idx(hit_idx)
  );

  typedef struct {
    logic       hit;
    logic [2:0] idx;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int issued = 0;
  int captured = 0;
  int popped = 0;
  bit done = 1'b0;

  task automatic note(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic io, input logic [31:0] a,
                      input logic eh, input logic [2:0] ei, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = v; req_is_io = io; req_addr = a;
    e.hit = eh; e.idx = ei; e.tag = tag;
    exp_q.push_back(e);
    issued++;
  endtask

  task automatic next_cfg();
    @(posedge clk); #1;
  endtask

  task automatic chk_en(input logic [6:0] exp, input string tag);
    @(negedge clk);
    note(win_en === exp, tag, $sformatf("%b", win_en), $sformatf("%b", exp));
  endtask

  always @(posedge clk) captured <= issued;

  always @(negedge clk) begin
    while (popped < captured && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      popped++;
      if (e.hit)
        note(hit === 1'b1 && hit_idx === e.idx, e.tag,
             $sformatf("hit=%b idx=%0d", hit, hit_idx), $sformatf("hit=1 idx=%0d", e.idx));
      else
        note(hit === 1'b0, e.tag, $sformatf("hit=%b", hit), "hit=0");
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bars[0] = 32'h0000_C001; bars[1] = 32'hFEB0_0000; bars[2] = 32'h0000_C101;
    bars[3] = 32'hFEB0_0008; bars[4] = 32'h2000_0000; bars[5] = 32'h3000_0000;
    rom_reg = 32'hFFF0_0001;
    cmd_en  = 2'b11;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    note(hit === 1'b0 && hit_idx === 3'd0, "R11 reset",
         $sformatf("hit=%b idx=%0d", hit, hit_idx), "hit=0 idx=0");

    chk_en(7'b1001111, "R7 R5 base config live set");
    send(1, 1, 32'h0000_C005, 1, 0, "R2 io inside");
    send(1, 1, 32'h0000_C00F, 1, 0, "R2 io last byte");
    send(1, 1, 32'h0000_C010, 0, 0, "R2 io past end");
    send(1, 1, 32'h0000_BFFF, 0, 0, "R2 io below base");
    send(1, 1, 32'h0000_C1FF, 1, 2, "R2 io second window end");
    send(1, 0, 32'h0000_C005, 0, 0, "R8 mem access to io window");
    send(1, 1, 32'hFEB0_0004, 0, 0, "R8 io access to mem window");
    send(1, 0, 32'hFEB0_0004, 1, 1, "R9 overlap lowest wins");
    send(1, 0, 32'hFEB0_1000, 1, 3, "R9 only large window");
    send(1, 0, 32'hFEBF_FFFF, 1, 3, "R2 mem last byte");
    send(1, 0, 32'hFEC0_0000, 0, 0, "R2 mem past end");
    send(1, 0, 32'h2000_0000, 0, 0, "R5 size one window");
    send(1, 0, 32'h3000_0000, 0, 0, "R7 absent window");
    send(1, 0, 32'hFFF0_FFFF, 1, 6, "R6 rom hit");
    send(0, 0, 32'hFEB0_0004, 0, 0, "R10 valid low");

    next_cfg(); rom_reg = 32'hFFF0_0000;
    chk_en(7'b0001111, "R6 rom enable clear");
    send(1, 0, 32'hFFF0_1234, 0, 0, "R6 rom off no hit");

    next_cfg(); cmd_en = 2'b01;
    chk_en(7'b0000101, "R1 memory decode off");
    send(1, 0, 32'hFEB0_0004, 0, 0, "R1 memory off no hit");
    send(1, 1, 32'h0000_C005, 1, 0, "R1 io still on");

    next_cfg(); cmd_en = 2'b10;
    chk_en(7'b0001010, "R1 io decode off");
    send(1, 1, 32'h0000_C005, 0, 0, "R1 io off no hit");

    next_cfg(); cmd_en = 2'b11; rom_reg = 32'hFFF0_0001; bars[0] = 32'h0000_0001;
    chk_en(7'b1001110, "R3 zero base");
    send(1, 1, 32'h0000_0005, 0, 0, "R3 zero base no hit");

    next_cfg(); bars[2] = 32'h0000_FF01;
    chk_en(7'b1001110, "R4 io window ending at ffff");
    send(1, 1, 32'h0000_FFFF, 1, 2, "R4 io top byte");

    next_cfg(); bars[2] = 32'h0001_0001;
    chk_en(7'b1001010, "R4 io window above 64K");
    send(1, 1, 32'h0001_0005, 0, 0, "R4 io above 64K no hit");

    send(0, 0, 32'h0, 0, 0, "R10 drain");
    repeat (4) @(posedge clk);
    @(negedge clk);
    note(exp_q.size() == 0, "R10 scoreboard drained",
         $sformatf("%0d", exp_q.size()), "0");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule